// File: doc/BRIEF.md
# S/T-Interface Layer-1 Activation Controller

This block runs layer-1 activation and deactivation for a basic-rate S/T line. One state machine serves both ends of the line. A static mode input picks the network side or the terminal side. That choice sets which INFO codes the block expects on receive and which it sends on transmit. Decoded line indications arrive on plain inputs: the received INFO code, frame sync, multiframe sync and an activation-timer expiry strobe. The block drives a 3-bit INFO code for the line coder.

A host microcontroller reaches the block through two 4-bit nibbles. The control nibble can be read and written. It carries an activation request, a deactivation request that applies to the network side only, an activation-timer-expired strobe and a terminal-class flag. The status nibble is read-only. It shows whether the line is active, whether the block is in error, multiframe lock and frame lock. Error entry and error recovery show up as the rising and falling edges of the single error bit. The active-low hardware reset and the active-high software reset both act synchronously and bring the block to idle.

Top module: `st_act_ctrl`

## Requirements
- R1: With rst_n low or sw_rst high at a clock edge, ctrl_q and stat_q read 0 and tx_info reads 0 (INFO 0) after that edge. INFO n is coded as the value n, for n from 0 to 4.
- R2: A write (wr_en high) loads wr_data into ctrl_q at the next edge. ctrl_q[3] is the activation request, ctrl_q[2] the deactivation request, ctrl_q[1] the timer-expired strobe and ctrl_q[0] the terminal class. As terminal side (is_nt=0), ctrl_q[2] always loads 0. ctrl_q[1] returns to 0 on the first edge with no write.
- R3: In idle, a set activation request moves tx_info on the next edge to 2 as network side or to 1 as terminal side. As network side, rx_info=1 in idle gives the same result. As terminal side, rx_info=2 in idle moves tx_info to 3.
- R4: During activation, the network side goes from sending 2 to sending 4 once it receives rx_info=3 with rx_fsync=1. The terminal side goes from sending 1 to sending 3 once it receives rx_info=2 with rx_fsync=1. It then becomes active, still sending 3, once it receives rx_info=4 with rx_fsync=1.
- R5: stat_q[3] is 1 only in the active state. There tx_info is 4 as network side or 3 as terminal side. The previous cycle saw rx_info at 3 (network) or 4 (terminal), with frame sync.
- R6: The activation request bit clears on the edge after the active state is first observed, unless a write occurs on that edge.
- R7: While active, losing the expected received INFO or frame sync sets stat_q[2] and moves tx_info to 2 (network) or 0 (terminal) on the next edge. Regaining both clears stat_q[2] and returns to the active state.
- R8: As network side, a set deactivation request moves any state other than idle to a state that sends 0. That state returns to idle once rx_info=0. The request bit clears on the edge after idle is observed.
- R9: A timer expiry (ctrl_q[1] set, or tmr_exp high) during activation or error moves the block to the sending-0 deactivation state and clears the activation request. In idle, active or deactivation it has no effect.
- R10: stat_q[0] shows rx_fsync from the previous edge. stat_q[1] shows rx_mfsync from the previous edge as terminal side and stays 0 as network side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hardware reset, synchronous, active low |
| sw_rst | input | 1 | Software reset, synchronous, active high |
| is_nt | input | 1 | Role select: 1 network side, 0 terminal side |
| wr_en | input | 1 | Control nibble write strobe |
| wr_data | input | 4 | Control nibble write data |
| ctrl_q | output | 4 | Control nibble read-back |
| stat_q | output | 4 | Status nibble {active, error, multiframe, frame} |
| rx_info | input | 3 | Decoded received INFO code |
| rx_fsync | input | 1 | Frame sync held |
| rx_mfsync | input | 1 | Multiframe sync held |
| tmr_exp | input | 1 | Activation timer expiry strobe |
| tx_info | output | 3 | INFO code to transmit |

## Verification
The assertions assume that is_nt changes only while a reset is applied, and that rx_info carries only the codes 0 to 4. The stimulus changes the role only in cycles where rst_n is low. It draws received codes from 0 to 4, mostly the code that advances the present state, so that activation, error and recovery all occur often. Frame and multiframe sync drop at random, and writes, timer strobes and software resets arrive at random, sparse moments.

// File: rtl/st_act_pkg.sv
// Shared codes and types for the S/T activation controller.
// Assumes INFO n is carried as the binary value n on a 3-bit bus.
package st_act_pkg;
    localparam int NIB_W  = 4;
    localparam int INFO_W = 3;

    localparam logic [INFO_W-1:0] CODE_I0 = 3'd0;
    localparam logic [INFO_W-1:0] CODE_I1 = 3'd1;
    localparam logic [INFO_W-1:0] CODE_I2 = 3'd2;
    localparam logic [INFO_W-1:0] CODE_I3 = 3'd3;
    localparam logic [INFO_W-1:0] CODE_I4 = 3'd4;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_REQ   = 3'd1,
        PH_SYNC  = 3'd2,
        PH_ACT   = 3'd3,
        PH_ERR   = 3'd4,
        PH_DEACT = 3'd5
    } phase_t;

    typedef struct packed {
        logic act_req;
        logic deact_req;
        logic tmr_flag;
        logic term_cls;
    } ctrl_t;
endpackage

// File: rtl/st_ctrl_nib.sv
// Control nibble: host-writable, with self-clearing bits driven by the FSM.
// Assumes is_nt is static outside reset; a write wins over any self-clear.
module st_ctrl_nib
    import st_act_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             is_nt,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] wr_data,
    input  logic             clr_act,
    input  logic             clr_deact,
    output ctrl_t            ctrl_o
);
    ctrl_t ctrl_q;

    // Update the nibble from a host write, or apply self-clears.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q.act_req   <= wr_data[3];
            ctrl_q.deact_req <= wr_data[2] & is_nt;
            ctrl_q.tmr_flag  <= wr_data[1];
            ctrl_q.term_cls  <= wr_data[0];
        end else begin
            ctrl_q.act_req   <= ctrl_q.act_req & ~clr_act;
            ctrl_q.deact_req <= ctrl_q.deact_req & ~clr_deact;
            ctrl_q.tmr_flag  <= 1'b0;
        end
    end

    assign ctrl_o = ctrl_q;

    // R2
    tmr_selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (ctrl_q.tmr_flag && !wr_en) |=> !ctrl_q.tmr_flag);

    // R2
    te_no_deact_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        !is_nt |-> !ctrl_q.deact_req);
endmodule

// File: rtl/st_act_fsm.sv
// Activation state machine shared by both line roles; decodes the
// transmit INFO code from its phase. Assumes rx_info holds codes 0..4.
module st_act_fsm
    import st_act_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_rst,
    input  logic              is_nt,
    input  logic              act_req,
    input  logic              deact_req,
    input  logic              tmr_flag,
    input  logic              tmr_exp,
    input  logic [INFO_W-1:0] rx_info,
    input  logic              rx_fsync,
    output phase_t            phase_o,
    output logic [INFO_W-1:0] tx_info,
    output logic              clr_act,
    output logic              clr_deact
);
    phase_t phase_q, phase_d;
    logic   line_ok;
    logic   pending;
    logic   abort;
    logic   drop;

    // Far-end code that confirms a healthy active line, with frame lock.
    assign line_ok = (rx_info == (is_nt ? CODE_I3 : CODE_I4)) && rx_fsync;
    assign pending = (phase_q == PH_REQ) || (phase_q == PH_SYNC) || (phase_q == PH_ERR);
    assign abort   = (tmr_flag || tmr_exp) && pending;
    assign drop    = is_nt && deact_req && (phase_q != PH_IDLE) && (phase_q != PH_DEACT);

    // Next-phase selection with deactivation, then timer, taking priority.
    always_comb begin
        phase_d = phase_q;
        if (drop || abort) begin
            phase_d = PH_DEACT;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (act_req)                          phase_d = PH_REQ;
                    else if (is_nt && rx_info == CODE_I1)  phase_d = PH_REQ;
                    else if (!is_nt && rx_info == CODE_I2) phase_d = PH_SYNC;
                end
                PH_REQ: begin
                    if (is_nt && line_ok)                  phase_d = PH_ACT;
                    else if (!is_nt && rx_info == CODE_I2 && rx_fsync) phase_d = PH_SYNC;
                end
                PH_SYNC:  if (line_ok)              phase_d = PH_ACT;
                PH_ACT:   if (!line_ok)             phase_d = PH_ERR;
                PH_ERR:   if (line_ok)              phase_d = PH_ACT;
                PH_DEACT: if (rx_info == CODE_I0)   phase_d = PH_IDLE;
                default:                            phase_d = PH_IDLE;
            endcase
        end
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) phase_q <= PH_IDLE;
        else                  phase_q <= phase_d;
    end

    // Transmit code per phase and role.
    always_comb begin
        case (phase_q)
            PH_REQ:  tx_info = is_nt ? CODE_I2 : CODE_I1;
            PH_SYNC: tx_info = CODE_I3;
            PH_ACT:  tx_info = is_nt ? CODE_I4 : CODE_I3;
            PH_ERR:  tx_info = is_nt ? CODE_I2 : CODE_I0;
            default: tx_info = CODE_I0;
        endcase
    end

    assign phase_o   = phase_q;
    assign clr_act   = (phase_q == PH_ACT) || abort;
    assign clr_deact = (phase_q == PH_IDLE);

    // R5
    act_rx_seen_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (phase_q == PH_ACT) |-> ($past(rx_fsync) &&
            $past(rx_info) == ($past(is_nt) ? CODE_I3 : CODE_I4)));

    // R7
    err_from_act_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        $rose(phase_q == PH_ERR) |-> ($past(phase_q) == PH_ACT));

    // R8
    deact_wait_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        ($past(phase_q) == PH_DEACT && phase_q == PH_IDLE) |-> ($past(rx_info) == CODE_I0));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (phase_q == PH_IDLE) |-> (tx_info == CODE_I0));
endmodule

// File: rtl/st_stat_nib.sv
// Status nibble: activation and error from the phase, line locks registered.
// Assumes is_nt is static outside reset.
module st_stat_nib
    import st_act_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_rst,
    input  logic             is_nt,
    input  phase_t           phase_i,
    input  logic             rx_fsync,
    input  logic             rx_mfsync,
    output logic [NIB_W-1:0] stat_o
);
    logic fs_q;
    logic mf_q;

    // Capture frame lock, and multiframe lock for the terminal role only.
    always_ff @(posedge clk) begin
        if (!rst_n || sw_rst) begin
            fs_q <= 1'b0;
            mf_q <= 1'b0;
        end else begin
            fs_q <= rx_fsync;
            mf_q <= rx_mfsync & ~is_nt;
        end
    end

    assign stat_o = {phase_i == PH_ACT, phase_i == PH_ERR, mf_q, fs_q};

    // R10
    nt_mf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        (is_nt && $past(is_nt)) |-> !mf_q);
endmodule

// File: rtl/st_act_ctrl.sv
// Top of the S/T layer-1 activation controller: control nibble, state
// machine and status nibble. Assumes is_nt changes only under reset.
module st_act_ctrl
    import st_act_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sw_rst,
    input  logic        is_nt,
    input  logic        wr_en,
    input  logic [3:0]  wr_data,
    output logic [3:0]  ctrl_q,
    output logic [3:0]  stat_q,
    input  logic [2:0]  rx_info,
    input  logic        rx_fsync,
    input  logic        rx_mfsync,
    input  logic        tmr_exp,
    output logic [2:0]  tx_info
);
    ctrl_t  ctrl_w;
    phase_t phase_w;
    logic   clr_act_w;
    logic   clr_deact_w;

    st_ctrl_nib u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .is_nt     (is_nt),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .clr_act   (clr_act_w),
        .clr_deact (clr_deact_w),
        .ctrl_o    (ctrl_w)
    );

    st_act_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .is_nt     (is_nt),
        .act_req   (ctrl_w.act_req),
        .deact_req (ctrl_w.deact_req),
        .tmr_flag  (ctrl_w.tmr_flag),
        .tmr_exp   (tmr_exp),
        .rx_info   (rx_info),
        .rx_fsync  (rx_fsync),
        .phase_o   (phase_w),
        .tx_info   (tx_info),
        .clr_act   (clr_act_w),
        .clr_deact (clr_deact_w)
    );

    st_stat_nib u_stat (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_rst    (sw_rst),
        .is_nt     (is_nt),
        .phase_i   (phase_w),
        .rx_fsync  (rx_fsync),
        .rx_mfsync (rx_mfsync),
        .stat_o    (stat_q)
    );

    assign ctrl_q = ctrl_w;

    // R5
    ai_tx_match_chk: assert property (@(posedge clk) disable iff (!rst_n || sw_rst)
        stat_q[3] |-> (tx_info == (is_nt ? CODE_I4 : CODE_I3)));
endmodule

// File: tb/st_act_ctrl_tb.sv
module st_act_ctrl_tb;
    localparam int CLK_NS   = 10;
    localparam int WD_LIMIT = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_rst = 1'b0;
    logic       is_nt = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] wr_data = '0;
    logic [3:0] ctrl_q;
    logic [3:0] stat_q;
    logic [2:0] rx_info = '0;
    logic       rx_fsync = 1'b0;
    logic       rx_mfsync = 1'b0;
    logic       tmr_exp = 1'b0;
    logic [2:0] tx_info;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // bench model: 0 idle,1 request,2 sync,3 active,4 error,5 deact
    int m_ph = 0;
    bit m_act, m_deact, m_tmr, m_cls, m_fs, m_mf;

    st_act_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sw_rst(sw_rst), .is_nt(is_nt),
        .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q), .stat_q(stat_q),
        .rx_info(rx_info), .rx_fsync(rx_fsync), .rx_mfsync(rx_mfsync),
        .tmr_exp(tmr_exp), .tx_info(tx_info)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [2:0] exp_tx(int ph, bit n);
        case (ph)
            1: return n ? 3'd2 : 3'd1;
            2: return 3'd3;
            3: return n ? 3'd4 : 3'd3;
            4: return n ? 3'd2 : 3'd0;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic [3:0] exp_stat();
        return {m_ph == 3, m_ph == 4, m_mf, m_fs};
    endfunction

    function automatic logic [3:0] exp_ctrl();
        return {m_act, m_deact, m_tmr, m_cls};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance the model by one edge using the values about to be sampled.
    task automatic model_step(bit hr, bit sr, bit wr, logic [3:0] d,
                              logic [2:0] rx, bit fs, bit mf, bit te);
        bit good, ab, dr;
        int nph;
        good = (rx == (is_nt ? 3'd3 : 3'd4)) && fs;
        ab   = (m_tmr || te) && (m_ph == 1 || m_ph == 2 || m_ph == 4);
        dr   = is_nt && m_deact && m_ph != 0 && m_ph != 5;
        nph  = m_ph;
        if (dr || ab) nph = 5;
        else case (m_ph)
            0: if (m_act || (is_nt && rx == 1) || (!is_nt && rx == 2))
                   nph = (m_act || is_nt) ? 1 : 2;
            1: if (is_nt && good) nph = 3;
               else if (!is_nt && rx == 2 && fs) nph = 2;
            2: if (good) nph = 3;
            3: if (!good) nph = 4;
            4: if (good) nph = 3;
            5: if (rx == 0) nph = 0;
            default: nph = 0;
        endcase
        if (!hr || sr) begin
            m_ph = 0; {m_act, m_deact, m_tmr, m_cls, m_fs, m_mf} = '0;
        end else begin
            if (wr) begin
                m_act = d[3]; m_deact = d[2] & is_nt; m_tmr = d[1]; m_cls = d[0];
            end else begin
                m_act   = m_act & ~(m_ph == 3 || ab);
                m_deact = m_deact & ~(m_ph == 0);
                m_tmr   = 1'b0;
            end
            m_fs = fs;
            m_mf = mf & ~is_nt;
            m_ph = nph;
        end
    endtask

    // Drive one cycle at the falling edge, then compare all outputs.
    task automatic tick(bit hr, bit sr, bit wr, logic [3:0] d,
                        logic [2:0] rx, bit fs, bit mf, bit te);
        rst_n = hr; sw_rst = sr; wr_en = wr; wr_data = d;
        rx_info = rx; rx_fsync = fs; rx_mfsync = mf; tmr_exp = te;
        model_step(hr, sr, wr, d, rx, fs, mf, te);
        @(posedge clk);
        @(negedge clk);
        chk("R4 tx_info", tx_info, exp_tx(m_ph, is_nt));
        chk("R5 stat_q", stat_q, exp_stat());
        chk("R2 ctrl_q", ctrl_q, exp_ctrl());
    endtask

    function automatic logic [2:0] want_rx();
        case (m_ph)
            0: return is_nt ? 3'd1 : 3'd2;
            1: return is_nt ? 3'd3 : 3'd2;
            2: return 3'd4;
            3, 4: return is_nt ? 3'd3 : 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    initial begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd2024));
        @(negedge clk);
        // R1: hardware reset state
        is_nt = 1'b1;
        tick(0, 0, 0, 4'h0, 0, 0, 0, 0);
        chk("R1 tx", tx_info, 0); chk("R1 stat", stat_q, 0); chk("R1 ctrl", ctrl_q, 0);

        // R3 / R4 / R5 / R6: network side activation
        tick(1, 0, 1, 4'b1000, 0, 0, 0, 0);
        chk("R2 act req stored", ctrl_q, 4'b1000);
        tick(1, 0, 0, 4'h0, 0, 0, 0, 0);
        chk("R3 NT sends INFO2", tx_info, 2);
        tick(1, 0, 0, 4'h0, 3, 1, 0, 0);
        chk("R4 NT sends INFO4", tx_info, 4);
        chk("R5 NT active bit", stat_q[3], 1);
        tick(1, 0, 0, 4'h0, 3, 1, 1, 0);
        chk("R6 act req cleared", ctrl_q[3], 0);
        chk("R10 NT mf bit zero", stat_q[1], 0);

        // R7: error entry and recovery
        tick(1, 0, 0, 4'h0, 0, 1, 0, 0);
        chk("R7 error set", stat_q[2], 1);
        chk("R7 NT error INFO2", tx_info, 2);
        tick(1, 0, 0, 4'h0, 3, 1, 0, 0);
        chk("R7 error cleared", stat_q[2], 0);
        chk("R7 back active", stat_q[3], 1);

        // R9: timer ignored while active
        tick(1, 0, 0, 4'h0, 3, 1, 0, 1);
        chk("R9 timer ignored in active", tx_info, 4);

        // R8: deactivation request
        tick(1, 0, 1, 4'b0100, 3, 1, 0, 0);
        tick(1, 0, 0, 4'h0, 3, 1, 0, 0);
        chk("R8 deact sends INFO0", tx_info, 0);
        tick(1, 0, 0, 4'h0, 3, 1, 0, 0);
        chk("R8 waits for INFO0", stat_q[3], 0);
        tick(1, 0, 0, 4'h0, 0, 1, 0, 0);
        tick(1, 0, 0, 4'h0, 0, 1, 0, 0);
        chk("R8 deact bit cleared", ctrl_q[2], 0);

        // R1: software reset
        tick(1, 0, 1, 4'b1001, 1, 1, 1, 0);
        tick(1, 1, 0, 4'h0, 1, 1, 1, 0);
        chk("R1 sw reset stat", stat_q, 0); chk("R1 sw reset ctrl", ctrl_q, 0);

        // R2 / R3 / R4 / R10: terminal side
        is_nt = 1'b0;
        tick(0, 0, 0, 4'h0, 0, 0, 0, 0);
        tick(1, 0, 1, 4'b1100, 0, 0, 0, 0);
        chk("R2 TE deact ignored", ctrl_q, 4'b1000);
        tick(1, 0, 0, 4'h0, 0, 0, 0, 0);
        chk("R3 TE sends INFO1", tx_info, 1);
        tick(1, 0, 0, 4'h0, 2, 1, 0, 0);
        chk("R4 TE sends INFO3", tx_info, 3);
        chk("R5 TE not yet active", stat_q[3], 0);
        tick(1, 0, 0, 4'h0, 4, 1, 1, 0);
        chk("R5 TE active", stat_q[3], 1);
        chk("R10 TE mf bit", stat_q[1], 1);
        chk("R10 fs bit", stat_q[0], 1);
        tick(1, 0, 0, 4'h0, 4, 0, 1, 0);
        chk("R7 TE error INFO0", tx_info, 0);

        // R9: timer during error, then in idle
        tick(1, 0, 1, 4'b1010, 0, 0, 0, 0);
        chk("R2 timer bit reads 1", ctrl_q[1], 1);
        tick(1, 0, 0, 4'h0, 0, 0, 0, 0);
        chk("R9 timer abort INFO0", tx_info, 0);
        chk("R9 act req dropped", ctrl_q[3], 0);
        chk("R9 error cleared", stat_q[2], 0);
        tick(1, 0, 0, 4'h0, 0, 0, 0, 0);
        tick(1, 0, 0, 4'h0, 0, 0, 0, 1);
        chk("R9 timer ignored in idle", tx_info, 0);

        // Constrained random episodes, role changed only under reset.
        for (int ep = 0; ep < 12; ep++) begin
            is_nt = 1'($urandom % 2);
            tick(0, 0, 0, 4'h0, 0, 0, 0, 0);
            for (int c = 0; c < 250; c++) begin
                logic [2:0] rx;
                rx = ($urandom % 10 < 7) ? want_rx() : 3'($urandom % 5);
                tick(1, ($urandom % 300) == 0, ($urandom % 15) == 0, 4'($urandom),
                     rx, ($urandom % 10) != 0, ($urandom % 4) != 0, ($urandom % 40) == 0);
            end
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule